// File: doc/BRIEF.md
# SD/MMC Host Command-Line Sequencer

This block runs the command side of an SD/MMC host. When software or a host controller raises a start request with the enable held high, the block does two things. First, it builds a 48-bit command frame from a 6-bit index and a 32-bit argument, and shifts that frame out MSB first on the CMD line while asserting the output enable. Second, it releases the line. If a response is expected, it then waits for the card to pull the line low, and shifts in a 48-bit short or 136-bit long response while checking the CRC7 carried in it.

A command can be parked until the data path raises a stop request, so that a stop command goes out exactly when the data transfer ends. A second mode is meant for cards that answer only on an interrupt: it turns off the response timer, and the block then waits without limit. In the normal mode the card gets 64 clocks to begin its answer. After every command the block spends at least 8 clocks idle before it accepts the next one.

Top module: `sdmmc_cmd_path`

## Requirements
- R1: After reset the block is idle. `cmd_line_oe`, `cmd_busy` and all four status pulses are 0.
- R2: An accepted command drives `cmd_line_oe` high for exactly 48 cycles, starting the cycle after acceptance. The frame goes out MSB first as: 0, 1, index[5:0], argument[31:0], CRC7[6:0], 1. The CRC7 uses the polynomial x^7+x^3+1 (0x09), starts from zero, and covers the first 40 bits. Index 0 with argument 0 gives 48'h400000000095.
- R3: With `mode_pend` set, an accepted command waits without driving the line until `data_stop_req` is sampled high. Transmission starts the cycle after that.
- R4: Dropping `cmd_en` while parked, while waiting for a response, or while receiving returns the block to idle in one cycle. No done or timeout pulse is raised.
- R5: When the last frame bit has gone out, `cmd_sent` pulses for one cycle. The block goes idle if no response is expected or if `cmd_en` is low. Otherwise it waits for a response.
- R6: In normal mode, if the line stays high for 64 waiting cycles, `resp_timeout` pulses in the next cycle and the block goes idle. A start bit seen in the 64th waiting cycle is still accepted.
- R7: With `mode_irq` set, no timeout is raised. The block waits for the start bit indefinitely.
- R8: A short response is 48 bits. After it, `resp_bits[46:0]` holds frame bits 46..0 (everything after the start bit), the upper bits are 0, and `resp_done` pulses.
- R9: A long response is 136 bits. After it, `resp_bits[127:0]` holds frame bits 127..0. The CRC7 is computed over bits 127..8 and compared with bits 7..1.
- R10: For a short response the CRC covers bits 47..8. If the received bits 7..1 differ from the computed CRC, `resp_crc_err` pulses together with `resp_done`. Otherwise it stays 0.
- R11: The block spends at least 8 cycles idle between commands. A start request seen earlier is dropped, not held. A request in the 8th idle cycle is accepted.
- R12: A start request while `cmd_en` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Enable level; dropping it aborts a waiting command |
| cmd_start | input | 1 | Start request strobe |
| mode_pend | input | 1 | Park the command until the data path asks for it |
| mode_irq | input | 1 | Disable the response timer |
| resp_expect | input | 1 | A response follows the command |
| resp_long | input | 1 | Response is 136 bits rather than 48 |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| data_stop_req | input | 1 | Release strobe from the data path |
| cmd_line_in | input | 1 | Sampled level of the CMD line |
| cmd_line_out | output | 1 | Value driven onto the CMD line |
| cmd_line_oe | output | 1 | Output enable for the CMD line |
| resp_bits | output | 128 | Captured response bits |
| cmd_busy | output | 1 | High whenever the block is not idle |
| cmd_sent | output | 1 | Pulse: last command bit sent |
| resp_done | output | 1 | Pulse: full response received |
| resp_crc_err | output | 1 | Pulse: response CRC mismatch |
| resp_timeout | output | 1 | Pulse: no response within the window |

## Verification
The in-line assertions check the cycle-level rules on every cycle:
- the output enable lasts exactly one frame length;
- the block never leaves idle before the 8-cycle gap;
- a timeout is raised only after exactly 64 waiting cycles, and never in interrupt mode;
- a parked command holds until it is released;
- an abort is silent;
- a CRC error never appears without its done pulse.

Only the bench's scenarios show the data content: that the serialized bits match an independently computed frame and CRC, that captured short and long responses land in the right bit positions, and that corrupted CRCs are flagged. The same goes for the boundary cases of a start bit arriving in the last waiting cycle and a start request landing one cycle before or exactly at the end of the gap.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int IDX_W      = 6;
  localparam int ARG_W      = 32;
  localparam int CRC_W      = 7;
  localparam int HEAD_W     = 2 + IDX_W + ARG_W;
  localparam int CMD_BITS   = HEAD_W + CRC_W + 1;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int RESP_W     = 128;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PEND = 3'd1,
    ST_SEND = 3'd2,
    ST_WAIT = 3'd3,
    ST_RECV = 3'd4
  } cmd_state_e;

  // One serial step of CRC7 with generator x^7 + x^3 + 1.
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_of_head(input logic [HEAD_W-1:0] m);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) c = crc7_step(c, m[i]);
    return c;
  endfunction

  // Command frame: start 0, direction 1, index, argument, CRC7, end 1.
  function automatic logic [CMD_BITS-1:0] build_cmd(input logic [IDX_W-1:0] idx,
                                                    input logic [ARG_W-1:0] arg);
    logic [HEAD_W-1:0] head;
    head = {2'b01, idx, arg};
    return {head, crc7_of_head(head), 1'b1};
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
#(
  parameter int FRAME_W = CMD_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  output logic               bit_o,
  output logic               last_o
);

  localparam int CW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load) begin
      sh  <= frame;
      cnt <= CW'(FRAME_W - 1);
    end else if (shift) begin
      sh <= {sh[FRAME_W-2:0], 1'b1};
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign bit_o  = sh[FRAME_W-1];
  assign last_o = (cnt == '0);

  // R2: a new frame is never loaded while one is being shifted out
  p_load_not_shifting_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift);

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int SHORT_LEN = SHORT_BITS,
  parameter int LONG_LEN  = LONG_BITS,
  parameter int CAP_W     = RESP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             is_long,
  input  logic             sample,
  input  logic             din,
  output logic [CAP_W-1:0] resp_o,
  output logic             last_o,
  output logic             crc_bad_o
);

  localparam int PW = $clog2(LONG_LEN);

  logic [CAP_W-1:0] sh;
  logic [PW-1:0]    pos;
  logic [CRC_W-1:0] crc;
  logic             long_q;

  // Bit positions that feed the CRC: short covers everything above the CRC
  // field, long skips the 8 header bits.
  function automatic logic in_crc_window(input logic [PW-1:0] p, input logic lng);
    logic [PW-1:0] top;
    top = lng ? PW'(CAP_W - 1) : PW'(SHORT_LEN - 2);
    return (p >= PW'(CRC_W + 1)) && (p <= top);
  endfunction

  logic use_bit;
  assign use_bit = in_crc_window(pos, long_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      pos    <= '0;
      crc    <= '0;
      long_q <= 1'b0;
    end else if (arm) begin
      sh     <= '0;
      long_q <= is_long;
      pos    <= is_long ? PW'(LONG_LEN - 2) : PW'(SHORT_LEN - 2);
      crc    <= is_long ? '0 : crc7_step('0, 1'b0);
    end else if (sample) begin
      sh <= {sh[CAP_W-2:0], din};
      if (use_bit) crc <= crc7_step(crc, din);
      if (pos != '0) pos <= pos - 1'b1;
    end
  end

  assign resp_o    = sh;
  assign last_o    = (pos == '0);
  assign crc_bad_o = (crc != sh[CRC_W-1:0]);

  // R8: capture never restarts in the middle of a sampling cycle
  p_arm_not_sampling_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !sample);

endmodule

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
  import sdcmd_pkg::*;
#(
  parameter int TOUT_CYC = 64,
  parameter int GAP_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic       pend_mode,
  input  logic       irq_mode,
  input  logic       resp_exp,
  input  logic       resp_long,
  input  logic       data_pend,
  input  logic       line_low,
  input  logic       tx_last,
  input  logic       rx_last,
  input  logic       rx_crc_bad,
  output cmd_state_e state_o,
  output logic       accept_o,
  output logic       tx_shift_o,
  output logic       rx_arm_o,
  output logic       rx_sample_o,
  output logic       long_o,
  output logic       sent_o,
  output logic       done_o,
  output logic       crc_err_o,
  output logic       tout_o
);

  localparam int TW = $clog2(TOUT_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  cmd_state_e    state, nxt;
  logic          resp_q, irq_q, long_q;
  logic [TW-1:0] tmr;
  logic [GW-1:0] idle_cnt;

  // Named internal events
  logic gap_ok, evt_accept, evt_tx_end, evt_rx_start, evt_rx_end, evt_timeout;

  assign gap_ok       = (idle_cnt == GW'(GAP_CYC - 1));
  assign evt_accept   = (state == ST_IDLE) && en && start && gap_ok;
  assign evt_tx_end   = (state == ST_SEND) && tx_last;
  assign evt_rx_start = (state == ST_WAIT) && en && line_low;
  assign evt_timeout  = (state == ST_WAIT) && en && !line_low && !irq_q
                        && (tmr == TW'(TOUT_CYC - 1));
  assign evt_rx_end   = (state == ST_RECV) && en && rx_last;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (evt_accept) nxt = pend_mode ? ST_PEND : ST_SEND;
      ST_PEND: begin
        if (!en)            nxt = ST_IDLE;
        else if (data_pend) nxt = ST_SEND;
      end
      ST_SEND: if (tx_last) nxt = (en && resp_q) ? ST_WAIT : ST_IDLE;
      ST_WAIT: begin
        if (!en)              nxt = ST_IDLE;
        else if (line_low)    nxt = ST_RECV;
        else if (evt_timeout) nxt = ST_IDLE;
      end
      ST_RECV: begin
        if (!en)          nxt = ST_IDLE;
        else if (rx_last) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      resp_q    <= 1'b0;
      irq_q     <= 1'b0;
      long_q    <= 1'b0;
      tmr       <= '0;
      idle_cnt  <= '0;
      sent_o    <= 1'b0;
      done_o    <= 1'b0;
      crc_err_o <= 1'b0;
      tout_o    <= 1'b0;
    end else begin
      state <= nxt;
      if (evt_accept) begin
        resp_q <= resp_exp;
        irq_q  <= irq_mode;
        long_q <= resp_long;
      end
      if (state == ST_WAIT) tmr <= tmr + 1'b1;
      else                  tmr <= '0;
      if (state != ST_IDLE)  idle_cnt <= '0;
      else if (!gap_ok)      idle_cnt <= idle_cnt + 1'b1;
      sent_o    <= evt_tx_end;
      done_o    <= evt_rx_end;
      crc_err_o <= evt_rx_end && rx_crc_bad;
      tout_o    <= evt_timeout;
    end
  end

  assign state_o     = state;
  assign accept_o    = evt_accept;
  assign tx_shift_o  = (state == ST_SEND);
  assign rx_arm_o    = evt_rx_start;
  assign rx_sample_o = (state == ST_RECV) && en;
  assign long_o      = long_q;

  // R3: a parked command stays parked until released
  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND && en && !data_pend) |=> state == ST_PEND);

  // R4: an abort returns to idle without status
  p_abort_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PEND || state == ST_WAIT || state == ST_RECV) && !en)
      |=> (state == ST_IDLE && !done_o && !tout_o));

  // R7: no timeout while waiting in interrupt mode
  p_irq_no_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && irq_q) |=> !tout_o);

  // R10: a CRC error is only reported with a completed response
  p_crc_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_o |-> done_o);

  // R5: status pulses are mutually exclusive
  p_status_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sent_o, done_o, tout_o}));

endmodule

// File: rtl/sdmmc_cmd_path.sv
module sdmmc_cmd_path
  import sdcmd_pkg::*;
#(
  parameter int TOUT_CYC = 64,
  parameter int GAP_CYC  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en,
  input  logic          cmd_start,
  input  logic          mode_pend,
  input  logic          mode_irq,
  input  logic          resp_expect,
  input  logic          resp_long,
  input  logic [5:0]    cmd_index,
  input  logic [31:0]   cmd_arg,
  input  logic          data_stop_req,
  input  logic          cmd_line_in,
  output logic          cmd_line_out,
  output logic          cmd_line_oe,
  output logic [127:0]  resp_bits,
  output logic          cmd_busy,
  output logic          cmd_sent,
  output logic          resp_done,
  output logic          resp_crc_err,
  output logic          resp_timeout
);

  cmd_state_e          state;
  logic                accept, tx_shift, tx_last, rx_arm, rx_sample, rx_last, rx_crc_bad, long_sel;
  logic [CMD_BITS-1:0] frame;

  assign frame = build_cmd(cmd_index, cmd_arg);

  sdcmd_fsm #(.TOUT_CYC(TOUT_CYC), .GAP_CYC(GAP_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cmd_en),
    .start      (cmd_start),
    .pend_mode  (mode_pend),
    .irq_mode   (mode_irq),
    .resp_exp   (resp_expect),
    .resp_long  (resp_long),
    .data_pend  (data_stop_req),
    .line_low   (!cmd_line_in),
    .tx_last    (tx_last),
    .rx_last    (rx_last),
    .rx_crc_bad (rx_crc_bad),
    .state_o    (state),
    .accept_o   (accept),
    .tx_shift_o (tx_shift),
    .rx_arm_o   (rx_arm),
    .rx_sample_o(rx_sample),
    .long_o     (long_sel),
    .sent_o     (cmd_sent),
    .done_o     (resp_done),
    .crc_err_o  (resp_crc_err),
    .tout_o     (resp_timeout)
  );

  sdcmd_tx #(.FRAME_W(CMD_BITS)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .frame (frame),
    .shift (tx_shift),
    .bit_o (cmd_line_out),
    .last_o(tx_last)
  );

  sdcmd_rx #(.SHORT_LEN(SHORT_BITS), .LONG_LEN(LONG_BITS), .CAP_W(RESP_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (rx_arm),
    .is_long  (long_sel),
    .sample   (rx_sample),
    .din      (cmd_line_in),
    .resp_o   (resp_bits),
    .last_o   (rx_last),
    .crc_bad_o(rx_crc_bad)
  );

  assign cmd_line_oe = (state == ST_SEND);
  assign cmd_busy    = (state != ST_IDLE);

  // Run-length counters used only by the assertions below
  logic [31:0] a_idle_run, a_oe_run, a_wait_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_idle_run <= '0;
      a_oe_run   <= '0;
      a_wait_run <= '0;
    end else begin
      a_idle_run <= cmd_busy ? '0 : a_idle_run + 1;
      a_oe_run   <= cmd_line_oe ? a_oe_run + 1 : '0;
      a_wait_run <= (state == ST_WAIT) ? a_wait_run + 1 : '0;
    end
  end

  // R11: leaving idle only after the minimum gap
  p_idle_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !$past(cmd_busy)) |-> $past(a_idle_run) >= 32'(GAP_CYC - 1));

  // R2: the line is driven for exactly one frame
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_line_oe) |-> $past(a_oe_run) == 32'(CMD_BITS - 1));

  // R6: a timeout comes only after the full waiting window
  p_timeout_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_timeout |-> $past(a_wait_run) == 32'(TOUT_CYC - 1));

endmodule

// File: tb/sdmmc_cmd_path_tb.sv
module sdmmc_cmd_path_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_en = 1'b1, cmd_start = 1'b0, mode_pend = 1'b0, mode_irq = 1'b0;
  logic         resp_expect = 1'b0, resp_long = 1'b0, data_stop_req = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic         card_bit = 1'b1;
  logic         cmd_line_in, cmd_line_out, cmd_line_oe;
  logic [127:0] resp_bits;
  logic         cmd_busy, cmd_sent, resp_done, resp_crc_err, resp_timeout;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign cmd_line_in = cmd_line_oe ? cmd_line_out : card_bit;

  sdmmc_cmd_path u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_start(cmd_start),
    .mode_pend(mode_pend), .mode_irq(mode_irq), .resp_expect(resp_expect),
    .resp_long(resp_long), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .data_stop_req(data_stop_req), .cmd_line_in(cmd_line_in),
    .cmd_line_out(cmd_line_out), .cmd_line_oe(cmd_line_oe), .resp_bits(resp_bits),
    .cmd_busy(cmd_busy), .cmd_sent(cmd_sent), .resp_done(resp_done),
    .resp_crc_err(resp_crc_err), .resp_timeout(resp_timeout)
  );

  task automatic chk(input logic ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Remainder of message * x^7 divided by x^7+x^3+1 (long division form)
  function automatic logic [6:0] ref_crc(input logic [135:0] m, input int nbits);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < nbits + 7; k++) begin
      r = {r[6:0], (k < nbits) ? m[nbits-1-k] : 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [47:0] ref_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {1'b0, 1'b1, idx, arg};
    return {h, ref_crc({96'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] ref_short(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b00, idx, arg ^ 32'hA5A5_5A5A};
    return {88'b0, h, ref_crc({96'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] ref_long(input logic [31:0] arg);
    logic [119:0] p;
    p = {arg, ~arg, arg ^ 32'h0F0F_0F0F, arg[23:0]};
    return {2'b00, 6'h3F, p, ref_crc({16'b0, p}, 120), 1'b1};
  endfunction

  // Issues a command at a falling edge; returns at the falling edge after the last bit
  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic rexp, input logic rlong);
    logic [47:0] got;
    logic        oe_all;
    oe_all = 1'b1;
    cmd_index = idx; cmd_arg = arg; resp_expect = rexp; resp_long = rlong;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 47; i >= 0; i--) begin
      got[i] = cmd_line_out;
      oe_all = oe_all & cmd_line_oe;
      @(negedge clk);
    end
    chk(got == ref_cmd(idx, arg), "R2 frame bits", {88'b0, got}, {88'b0, ref_cmd(idx, arg)});
    chk(oe_all && !cmd_line_oe, "R2 output enable length", {135'b0, cmd_line_oe}, 136'd0);
    chk(cmd_sent == 1'b1, "R5 sent pulse", {135'b0, cmd_sent}, 136'd1);
    chk(cmd_busy == rexp, "R5 state after send", {135'b0, cmd_busy}, {135'b0, rexp});
  endtask

  task automatic send_resp(input logic [135:0] f, input int len, input int delay);
    repeat (delay) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      card_bit = f[i];
      @(negedge clk);
    end
    card_bit = 1'b1;
  endtask

  // idx, arg, expect response, long, corrupt CRC
  localparam logic [40:0] VEC [6] = '{
    {6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0},
    {6'd17, 32'h0000_0200, 1'b1, 1'b0, 1'b0},
    {6'd2,  32'h0000_0000, 1'b1, 1'b1, 1'b0},
    {6'd55, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1},
    {6'd9,  32'h1234_0000, 1'b1, 1'b1, 1'b1},
    {6'd63, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [135:0] rf;
    logic [127:0] exp_bits;
    logic         seen;
    int           n_to;

    repeat (3) @(negedge clk);
    chk(!cmd_line_oe && !cmd_busy, "R1 reset idle", {134'b0, cmd_line_oe, cmd_busy}, 136'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cmd_sent, resp_done, resp_crc_err, resp_timeout} == 4'b0, "R1 status clear",
        {132'b0, cmd_sent, resp_done, resp_crc_err, resp_timeout}, 136'd0);
    repeat (10) @(negedge clk);

    // Known-answer frame, R2
    send_cmd(6'd0, 32'h0, 1'b0, 1'b0);
    chk(ref_cmd(6'd0, 32'h0) == 48'h4000_0000_0095, "R2 reference CRC",
        {88'b0, ref_cmd(6'd0, 32'h0)}, {88'b0, 48'h4000_0000_0095});
    repeat (10) @(negedge clk);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      send_cmd(VEC[v][40:35], VEC[v][34:3], VEC[v][2], VEC[v][1]);
      if (VEC[v][2]) begin
        rf = VEC[v][1] ? ref_long(VEC[v][34:3]) : ref_short(VEC[v][40:35], VEC[v][34:3]);
        exp_bits = VEC[v][1] ? rf[127:0] : {81'b0, rf[46:0]};
        if (VEC[v][0]) rf[1] = ~rf[1];
        send_resp(rf, VEC[v][1] ? 136 : 48, 1 + v);
        chk(resp_done && !cmd_busy, "R8 response done", {134'b0, resp_done, cmd_busy}, 136'd2);
        chk(resp_crc_err == VEC[v][0], "R10 CRC flag", {135'b0, resp_crc_err}, {135'b0, VEC[v][0]});
        if (!VEC[v][0])
          chk(resp_bits == exp_bits, VEC[v][1] ? "R9 long capture" : "R8 short capture",
              {8'b0, resp_bits}, {8'b0, exp_bits});
      end
      repeat (10) @(negedge clk);
    end

    // R12: start while disabled
    cmd_en = 1'b0; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    @(negedge clk);
    chk(!cmd_busy && !cmd_line_oe, "R12 start ignored when disabled", {134'b0, cmd_busy, cmd_line_oe}, 136'd0);
    cmd_en = 1'b1;
    repeat (10) @(negedge clk);

    // R11: gap boundary
    send_cmd(6'd12, 32'h0, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    chk(!cmd_busy, "R11 early start dropped", {135'b0, cmd_busy}, 136'd0);
    @(negedge clk);
    cmd_start = 1'b0;
    chk(cmd_line_oe && cmd_busy, "R11 start on 8th idle cycle", {134'b0, cmd_line_oe, cmd_busy}, 136'd3);
    repeat (60) @(negedge clk);

    // R3: parked command released by the data path
    mode_pend = 1'b1; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (20) @(negedge clk);
    chk(cmd_busy && !cmd_line_oe, "R3 parked", {134'b0, cmd_busy, cmd_line_oe}, 136'd2);
    data_stop_req = 1'b1;
    @(negedge clk); data_stop_req = 1'b0;
    chk(cmd_line_oe, "R3 released", {135'b0, cmd_line_oe}, 136'd1);
    repeat (60) @(negedge clk);

    // R4: abort while parked
    cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (4) @(negedge clk);
    cmd_en = 1'b0;
    @(negedge clk);
    chk(!cmd_busy, "R4 abort in park", {135'b0, cmd_busy}, 136'd0);
    cmd_en = 1'b1; data_stop_req = 1'b1;
    @(negedge clk); data_stop_req = 1'b0;
    chk(!cmd_busy && !cmd_line_oe, "R4 release after abort ignored", {134'b0, cmd_busy, cmd_line_oe}, 136'd0);
    mode_pend = 1'b0;
    repeat (10) @(negedge clk);

    // R4: abort while waiting for a response
    send_cmd(6'd3, 32'h0, 1'b1, 1'b0);
    cmd_en = 1'b0;
    @(negedge clk);
    chk(!cmd_busy, "R4 abort in wait", {135'b0, cmd_busy}, 136'd0);
    cmd_en = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      seen = seen | resp_timeout | resp_done;
    end
    chk(!seen, "R4 no status after abort", {135'b0, seen}, 136'd0);

    // R4: abort during reception
    send_cmd(6'd4, 32'h1, 1'b1, 1'b0);
    rf = ref_short(6'd4, 32'h1);
    for (int i = 47; i >= 38; i--) begin
      card_bit = rf[i];
      @(negedge clk);
    end
    cmd_en = 1'b0;
    @(negedge clk);
    card_bit = 1'b1;
    chk(!cmd_busy && !resp_done, "R4 abort in receive", {134'b0, cmd_busy, resp_done}, 136'd0);
    cmd_en = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      seen = seen | resp_done;
    end
    chk(!seen, "R4 no done after receive abort", {135'b0, seen}, 136'd0);

    // R6: timeout after 64 waiting cycles
    send_cmd(6'd5, 32'h0, 1'b1, 1'b0);
    chk(!resp_timeout, "R6 no early timeout", {135'b0, resp_timeout}, 136'd0);
    n_to = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (resp_timeout && n_to == 0) n_to = i;
    end
    chk(n_to == 64, "R6 timeout cycle", 136'(n_to), 136'd64);
    chk(!cmd_busy, "R6 idle after timeout", {135'b0, cmd_busy}, 136'd0);
    repeat (10) @(negedge clk);

    // R6: start bit in the last waiting cycle is accepted
    send_cmd(6'd6, 32'h55, 1'b1, 1'b0);
    rf = ref_short(6'd6, 32'h55);
    send_resp(rf, 48, 63);
    chk(resp_done && !resp_crc_err, "R6 late start bit accepted", {134'b0, resp_done, resp_crc_err}, 136'd2);
    chk(resp_bits == {81'b0, rf[46:0]}, "R8 late response capture", {8'b0, resp_bits}, {89'b0, rf[46:0]});
    repeat (10) @(negedge clk);

    // R7: interrupt mode waits without a timeout
    mode_irq = 1'b1;
    send_cmd(6'd40, 32'h0, 1'b1, 1'b0);
    mode_irq = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      seen = seen | resp_timeout | !cmd_busy;
    end
    chk(!seen, "R7 no timeout in interrupt mode", {135'b0, seen}, 136'd0);
    rf = ref_short(6'd40, 32'h0);
    send_resp(rf, 48, 0);
    chk(resp_done && !cmd_busy, "R7 interrupt response received", {134'b0, resp_done, cmd_busy}, 136'd2);
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule